// File: doc/BRIEF.md
# Triggered Sample Pipeline Address Controller

This block handles the addressing of a circular analog sample memory that has 160 columns. On every clock it names the column that is written next. It keeps a record of the recent write order. When a level-1 trigger arrives, it uses that record to find the three columns written a programmable number of clocks earlier. It reserves those columns and appends their addresses to a readout queue. A reserved column stays reserved until its data has been read out, and the write pointer steps over it. A sample is therefore never overwritten while it waits, even when a trigger window runs across a reserved region.

The readout side takes the queue in arrival order. For each queued column it produces 32 channel strobes at half the clock rate, so each trigger gives 96 values in three sample groups. Once the last channel of a column has been read, the column is released. The block also reports the number of reserved columns, a per-column reservation map, the queue occupancy and an empty flag. A sticky flag shows that a trigger was lost.

A resynchronisation input sends the write pointer back to the lowest free column. Trigger timing measured from that event therefore selects a known column.

Top module: `trig_pipe_addr_ctrl`

## Requirements
- R1: After a synchronous active-low reset: write column 0, queue count 0, empty flag 1, overflow 0, data-valid 0, reserved-column count 0 and an all-zero reservation map.
- R2: With nothing reserved, the write column rises by one on each clock and wraps from 159 to 0.
- R3: Let n be the write slot of the trigger clock and L (3 to 127) the latency. An accepted trigger queues the columns written in slots n-L, n-L+1 and n-L+2, in that order, and reserves them from the next clock.
- R4: Bit c of the reservation map is 1 exactly while column c is held by at least one queued entry. The reserved-column count equals the number of ones in the map.
- R5: The write column never rests on a reserved column. From column w, the next write column is the first unreserved column after w in rising circular order. Reservations made or released in the same clock are taken into account.
- R6: A trigger whose three slots run across a reserved region returns the unreserved columns that were actually written, two before the region and one after it.
- R7: The queue holds 24 entries. A trigger is accepted only when the count is 21 or less. Otherwise it is dropped, and the overflow flag goes to 1 and stays there until reset. The empty flag is 1 exactly when the count is 0.
- R8: While the queue is non-empty, data-valid pulses on every second clock. The first pulse comes on the second non-empty clock. Each pulse carries the head column, a channel index from 0 to 31 in order, and a sample index that cycles 0, 1, 2 over successive columns.
- R9: The clock edge after channel 31 of a column removes that column from the queue and releases its reservation.
- R10: A resynchronisation clock makes the next write column the lowest unreserved column. The queue is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Synchronous reset, active low |
| resync_i | input | 1 | Return the write pointer to the lowest free column |
| trig_i | input | 1 | Level-1 trigger |
| lat_i | input | 7 | Trigger latency in clocks, 3 to 127 |
| wr_col_o | output | 8 | Column written this clock |
| blk_mask_o | output | 160 | Reservation map, bit c for column c |
| blk_count_o | output | 8 | Number of reserved columns |
| q_count_o | output | 5 | Queue occupancy |
| q_empty_o | output | 1 | Queue empty |
| ovf_o | output | 1 | Sticky lost-trigger flag |
| rd_valid_o | output | 1 | Readout strobe |
| rd_col_o | output | 8 | Column under readout |
| rd_samp_o | output | 2 | Sample index within the trigger |
| rd_chan_o | output | 5 | Channel index |

## Verification
Some invariants are checked on every cycle. The write column is never reserved. It moves on every clock that has no resync. The overflow flag never falls. The queue stays within its capacity. The reserved-column count never exceeds the queue count. Readout strobes are separated by an idle clock and only name reserved columns while the queue is non-empty. Other behaviour can only be shown by the bench scenarios. These are the exact columns a trigger picks from the write history, the straddle case around a reserved region, the precise clock on which a column is released, the drop threshold, and where the pointer lands after a resync.

// File: rtl/tpa_pkg.sv
// Shared defaults and helpers for the triggered pipeline address controller.
// Assumes every modular addition adds a step smaller than the modulus.
package tpa_pkg;

    localparam int unsigned DEF_COLS    = 160;
    localparam int unsigned DEF_CHAN    = 32;
    localparam int unsigned DEF_SAMP    = 3;
    localparam int unsigned DEF_QDEPTH  = 24;
    localparam int unsigned DEF_HDEPTH  = 128;
    localparam int unsigned DEF_VAL_DIV = 2;

    // Adds step to base modulo modulus, for base < modulus and step < modulus.
    function automatic int unsigned wrap_add(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned modulus);
        int unsigned s;
        s = base + step;
        return (s >= modulus) ? (s - modulus) : s;
    endfunction

endpackage

// File: rtl/tpa_block_map.sv
// Per-column reservation counters. A column is reserved while its count is
// non-zero. Assumes no more than 2**REF_W - 1 queue entries name one column.
module tpa_block_map #(
    parameter int unsigned N_COLS = 160,
    parameter int unsigned N_SAMP = 3,
    parameter int unsigned COL_W  = 8,
    parameter int unsigned REF_W  = 5,
    parameter int unsigned CNT_W  = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             alloc_en,
    input  logic [N_SAMP-1:0][COL_W-1:0]     alloc_cols,
    input  logic                             free_en,
    input  logic [COL_W-1:0]                 free_col,
    output logic [N_COLS-1:0]                blk_mask,
    output logic [N_COLS-1:0]                blk_next,
    output logic [CNT_W-1:0]                 blk_count
);

    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        logic [REF_W-1:0] ref_q;
        logic [REF_W-1:0] ref_d;

        // Next count: one more per allocation hit, one less for a release.
        always_comb begin
            ref_d = ref_q;
            for (int k = 0; k < int'(N_SAMP); k++) begin
                if (alloc_en && (alloc_cols[k] == COL_W'(c))) begin
                    ref_d = ref_d + REF_W'(1);
                end
            end
            if (free_en && (free_col == COL_W'(c))) begin
                ref_d = ref_d - REF_W'(1);
            end
        end

        // Count register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ref_q <= '0;
            end else begin
                ref_q <= ref_d;
            end
        end

        assign blk_mask[c] = |ref_q;
        assign blk_next[c] = |ref_d;
    end

    // Population count of the current reservation map.
    always_comb begin
        blk_count = '0;
        for (int c = 0; c < int'(N_COLS); c++) begin
            blk_count = blk_count + CNT_W'(blk_mask[c]);
        end
    end

endmodule

// File: rtl/tpa_wr_ptr.sv
// Write pointer. It steps to the next free column each clock, or on a resync
// to the lowest free column. Assumes at least one column is always free.
module tpa_wr_ptr #(
    parameter int unsigned N_COLS = 160,
    parameter int unsigned COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resync,
    input  logic [N_COLS-1:0] blk_next,
    output logic [COL_W-1:0]  wr_col
);

    logic [COL_W-1:0] nxt_col;

    // Circular search for the first free column from the start point.
    always_comb begin
        int unsigned start;
        int unsigned idx;
        logic        found;
        start = resync ? 0 : tpa_pkg::wrap_add(int'(wr_col), 1, N_COLS);
        found = 1'b0;
        nxt_col = COL_W'(start);
        for (int unsigned i = 0; i < N_COLS; i++) begin
            idx = tpa_pkg::wrap_add(start, i, N_COLS);
            if (!found && !blk_next[idx]) begin
                nxt_col = COL_W'(idx);
                found   = 1'b1;
            end
        end
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_col <= '0;
        end else begin
            wr_col <= nxt_col;
        end
    end

endmodule

// File: rtl/tpa_hist.sv
// Ring of recently written column addresses, one entry per clock. It returns
// the N_SAMP columns that start lat slots before the current write.
// Assumes H_DEPTH is a power of two and N_SAMP <= lat < H_DEPTH.
module tpa_hist #(
    parameter int unsigned H_DEPTH = 128,
    parameter int unsigned N_SAMP  = 3,
    parameter int unsigned COL_W   = 8,
    parameter int unsigned LAT_W   = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [COL_W-1:0]             wr_col,
    input  logic [LAT_W-1:0]             lat,
    output logic [N_SAMP-1:0][COL_W-1:0] cells
);

    logic [COL_W-1:0] hist_q [H_DEPTH];
    logic [LAT_W-1:0] hptr_q;

    // Record the column written this clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hptr_q <= '0;
            for (int i = 0; i < int'(H_DEPTH); i++) begin
                hist_q[i] <= '0;
            end
        end else begin
            hist_q[hptr_q] <= wr_col;
            hptr_q         <= hptr_q + LAT_W'(1);
        end
    end

    // Look up the trigger window, oldest slot first.
    for (genvar k = 0; k < N_SAMP; k++) begin : g_cell
        logic [LAT_W-1:0] idx;
        assign idx      = hptr_q - lat + LAT_W'(k);
        assign cells[k] = hist_q[idx];
    end

endmodule

// File: rtl/tpa_queue.sv
// Readout queue of column addresses. A push writes N_SAMP entries at once and
// a pop removes one. The caller keeps pushes from overfilling it.
module tpa_queue #(
    parameter int unsigned Q_DEPTH = 24,
    parameter int unsigned N_SAMP  = 3,
    parameter int unsigned COL_W   = 8,
    parameter int unsigned QC_W    = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [N_SAMP-1:0][COL_W-1:0] push_cols,
    input  logic                         pop,
    output logic [COL_W-1:0]             head,
    output logic [QC_W-1:0]              count
);

    localparam int unsigned QA_W = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1;

    logic [COL_W-1:0] mem_q [Q_DEPTH];
    logic [QA_W-1:0]  rptr_q;
    logic [QA_W-1:0]  wptr_q;
    logic [QC_W-1:0]  count_q;

    // Storage writes for a three-entry push.
    always_ff @(posedge clk) begin
        if (push) begin
            for (int k = 0; k < int'(N_SAMP); k++) begin
                mem_q[QA_W'(tpa_pkg::wrap_add(int'(wptr_q), k, Q_DEPTH))] <= push_cols[k];
            end
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q  <= '0;
            wptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) begin
                wptr_q <= QA_W'(tpa_pkg::wrap_add(int'(wptr_q), N_SAMP, Q_DEPTH));
            end
            if (pop) begin
                rptr_q <= QA_W'(tpa_pkg::wrap_add(int'(rptr_q), 1, Q_DEPTH));
            end
            count_q <= count_q + (push ? QC_W'(N_SAMP) : QC_W'(0)) - (pop ? QC_W'(1) : QC_W'(0));
        end
    end

    assign head  = mem_q[rptr_q];
    assign count = count_q;

endmodule

// File: rtl/tpa_reader.sv
// Readout sequencer. It gives one strobe every VAL_DIV clocks while data
// waits, steps the channel index, and pops the head after the last channel.
module tpa_reader #(
    parameter int unsigned N_CHAN  = 32,
    parameter int unsigned N_SAMP  = 3,
    parameter int unsigned VAL_DIV = 2,
    parameter int unsigned CH_W    = 5,
    parameter int unsigned SM_W    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            have_data,
    output logic            valid,
    output logic            pop,
    output logic [CH_W-1:0] chan,
    output logic [SM_W-1:0] samp
);

    localparam int unsigned PH_W = (VAL_DIV > 1) ? $clog2(VAL_DIV) : 1;

    logic [PH_W-1:0] phase_q;
    logic [CH_W-1:0] chan_q;
    logic [SM_W-1:0] samp_q;

    assign valid = have_data && (phase_q == PH_W'(VAL_DIV - 1));
    assign pop   = valid && (chan_q == CH_W'(N_CHAN - 1));
    assign chan  = chan_q;
    assign samp  = samp_q;

    // Rate divider, channel and sample counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            chan_q  <= '0;
            samp_q  <= '0;
        end else begin
            if (have_data) begin
                phase_q <= (phase_q == PH_W'(VAL_DIV - 1)) ? '0 : phase_q + PH_W'(1);
            end
            if (valid) begin
                chan_q <= pop ? '0 : chan_q + CH_W'(1);
            end
            if (pop) begin
                samp_q <= (samp_q == SM_W'(N_SAMP - 1)) ? '0 : samp_q + SM_W'(1);
            end
        end
    end

endmodule

// File: rtl/trig_pipe_addr_ctrl.sv
// Triggered sample pipeline address controller. It ties together the write
// pointer, the write history, the reservation map, the readout queue and the
// readout sequencer. Assumes lat_i stays within N_SAMP .. H_DEPTH-1 and that
// H_DEPTH + Q_DEPTH < N_COLS, so a selected column is never rewritten before
// it is reserved.
module trig_pipe_addr_ctrl #(
    parameter int unsigned N_COLS  = tpa_pkg::DEF_COLS,
    parameter int unsigned N_CHAN  = tpa_pkg::DEF_CHAN,
    parameter int unsigned N_SAMP  = tpa_pkg::DEF_SAMP,
    parameter int unsigned Q_DEPTH = tpa_pkg::DEF_QDEPTH,
    parameter int unsigned H_DEPTH = tpa_pkg::DEF_HDEPTH,
    parameter int unsigned VAL_DIV = tpa_pkg::DEF_VAL_DIV,
    localparam int unsigned COL_W  = $clog2(N_COLS),
    localparam int unsigned LAT_W  = $clog2(H_DEPTH),
    localparam int unsigned CH_W   = $clog2(N_CHAN),
    localparam int unsigned SM_W   = $clog2(N_SAMP),
    localparam int unsigned QC_W   = $clog2(Q_DEPTH + 1),
    localparam int unsigned CNT_W  = $clog2(N_COLS + 1),
    localparam int unsigned REF_W  = $clog2(Q_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resync_i,
    input  logic              trig_i,
    input  logic [LAT_W-1:0]  lat_i,
    output logic [COL_W-1:0]  wr_col_o,
    output logic [N_COLS-1:0] blk_mask_o,
    output logic [CNT_W-1:0]  blk_count_o,
    output logic [QC_W-1:0]   q_count_o,
    output logic              q_empty_o,
    output logic              ovf_o,
    output logic              rd_valid_o,
    output logic [COL_W-1:0]  rd_col_o,
    output logic [SM_W-1:0]   rd_samp_o,
    output logic [CH_W-1:0]   rd_chan_o
);

    logic [N_SAMP-1:0][COL_W-1:0] cells;
    logic [N_COLS-1:0]            blk_next;
    logic [QC_W-1:0]              q_count;
    logic [COL_W-1:0]             q_head;
    logic                         accept;
    logic                         pop;
    logic                         ovf_q;

    assign accept = trig_i && (q_count <= QC_W'(Q_DEPTH - N_SAMP));

    tpa_wr_ptr #(
        .N_COLS (N_COLS),
        .COL_W  (COL_W)
    ) u_wr_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .resync   (resync_i),
        .blk_next (blk_next),
        .wr_col   (wr_col_o)
    );

    tpa_hist #(
        .H_DEPTH (H_DEPTH),
        .N_SAMP  (N_SAMP),
        .COL_W   (COL_W),
        .LAT_W   (LAT_W)
    ) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_col (wr_col_o),
        .lat    (lat_i),
        .cells  (cells)
    );

    tpa_block_map #(
        .N_COLS (N_COLS),
        .N_SAMP (N_SAMP),
        .COL_W  (COL_W),
        .REF_W  (REF_W),
        .CNT_W  (CNT_W)
    ) u_block_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (accept),
        .alloc_cols (cells),
        .free_en    (pop),
        .free_col   (q_head),
        .blk_mask   (blk_mask_o),
        .blk_next   (blk_next),
        .blk_count  (blk_count_o)
    );

    tpa_queue #(
        .Q_DEPTH (Q_DEPTH),
        .N_SAMP  (N_SAMP),
        .COL_W   (COL_W),
        .QC_W    (QC_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_cols (cells),
        .pop       (pop),
        .head      (q_head),
        .count     (q_count)
    );

    tpa_reader #(
        .N_CHAN  (N_CHAN),
        .N_SAMP  (N_SAMP),
        .VAL_DIV (VAL_DIV),
        .CH_W    (CH_W),
        .SM_W    (SM_W)
    ) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .have_data (q_count != '0),
        .valid     (rd_valid_o),
        .pop       (pop),
        .chan      (rd_chan_o),
        .samp      (rd_samp_o)
    );

    // Sticky flag for a trigger lost to a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (trig_i && !accept) begin
            ovf_q <= 1'b1;
        end
    end

    assign ovf_o     = ovf_q;
    assign q_count_o = q_count;
    assign q_empty_o = (q_count == '0);
    assign rd_col_o  = q_head;

endmodule

// File: rtl/tpa_checker.sv
// Cycle invariants of the controller, bound to the top module.
module tpa_checker #(
    parameter int unsigned N_COLS  = 160,
    parameter int unsigned Q_DEPTH = 24,
    parameter int unsigned VAL_DIV = 2,
    parameter int unsigned COL_W   = 8,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned QC_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              resync_i,
    input logic [COL_W-1:0]  wr_col_o,
    input logic [N_COLS-1:0] blk_mask_o,
    input logic [CNT_W-1:0]  blk_count_o,
    input logic [QC_W-1:0]   q_count_o,
    input logic              q_empty_o,
    input logic              ovf_o,
    input logic              rd_valid_o,
    input logic [COL_W-1:0]  rd_col_o
);

    p_wr_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_mask_o[wr_col_o]);

    p_wr_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !resync_i |=> (wr_col_o != $past(wr_col_o)));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    p_q_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q_count_o <= QC_W'(Q_DEPTH));

    p_blk_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(q_count_o) >= blk_count_o);

    p_valid_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> !q_empty_o);

    p_read_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> blk_mask_o[rd_col_o]);

    if (VAL_DIV > 1) begin : g_gap
        p_valid_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
            rd_valid_o |=> !rd_valid_o);
    end

endmodule

bind trig_pipe_addr_ctrl tpa_checker #(
    .N_COLS  (N_COLS),
    .Q_DEPTH (Q_DEPTH),
    .VAL_DIV (VAL_DIV),
    .COL_W   (COL_W),
    .CNT_W   (CNT_W),
    .QC_W    (QC_W)
) u_tpa_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .resync_i    (resync_i),
    .wr_col_o    (wr_col_o),
    .blk_mask_o  (blk_mask_o),
    .blk_count_o (blk_count_o),
    .q_count_o   (q_count_o),
    .q_empty_o   (q_empty_o),
    .ovf_o       (ovf_o),
    .rd_valid_o  (rd_valid_o),
    .rd_col_o    (rd_col_o)
);

// File: tb/test_trig_pipe_addr_ctrl.sv
// Bench for the triggered pipeline address controller. A behavioural model
// written from the requirements is compared with every output on every clock.
module test_trig_pipe_addr_ctrl;

    localparam int NC = 160;
    localparam int NQ = 24;
    localparam int WATCH_CYC = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         resync_i = 1'b0;
    logic         trig_i = 1'b0;
    logic [6:0]   lat_i = 7'd3;
    logic [7:0]   wr_col_o;
    logic [159:0] blk_mask_o;
    logic [7:0]   blk_count_o;
    logic [4:0]   q_count_o;
    logic         q_empty_o;
    logic         ovf_o;
    logic         rd_valid_o;
    logic [7:0]   rd_col_o;
    logic [1:0]   rd_samp_o;
    logic [4:0]   rd_chan_o;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    // Model state.
    int m_ref [NC];
    int m_hist [256];
    int m_q [$];
    int m_wr, m_hn, m_ph, m_ch, m_sm;
    bit m_ovf;

    trig_pipe_addr_ctrl i_trig_pipe_addr_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .resync_i    (resync_i),
        .trig_i      (trig_i),
        .lat_i       (lat_i),
        .wr_col_o    (wr_col_o),
        .blk_mask_o  (blk_mask_o),
        .blk_count_o (blk_count_o),
        .q_count_o   (q_count_o),
        .q_empty_o   (q_empty_o),
        .ovf_o       (ovf_o),
        .rd_valid_o  (rd_valid_o),
        .rd_col_o    (rd_col_o),
        .rd_samp_o   (rd_samp_o),
        .rd_chan_o   (rd_chan_o)
    );

    always #10 clk = ~clk;

    task automatic check(input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NC; c++) m_ref[c] = 0;
        for (int i = 0; i < 256; i++) m_hist[i] = 0;
        m_q.delete();
        m_wr = 0; m_hn = 0; m_ph = 0; m_ch = 0; m_sm = 0; m_ovf = 0;
    endtask

    function automatic int model_blocked_count();
        int n = 0;
        for (int c = 0; c < NC; c++) if (m_ref[c] != 0) n++;
        return n;
    endfunction

    // Compare every output with the model state of the current cycle.
    task automatic compare_all();
        logic [159:0] em;
        bit ev;
        check(int'(wr_col_o), m_wr, "R5 write column");
        check(int'(q_count_o), m_q.size(), "R7 queue count");
        check(int'(q_empty_o), int'(m_q.size() == 0), "R7 empty flag");
        check(int'(ovf_o), int'(m_ovf), "R7 overflow flag");
        ev = (m_q.size() > 0) && (m_ph == 1);
        check(int'(rd_valid_o), int'(ev), "R8 data valid");
        if (ev) begin
            check(int'(rd_col_o), m_q[0], "R8 readout column");
            check(int'(rd_chan_o), m_ch, "R8 channel index");
            check(int'(rd_samp_o), m_sm, "R8 sample index");
        end
        for (int c = 0; c < NC; c++) em[c] = (m_ref[c] != 0);
        n_checks++;
        if (blk_mask_o !== em) begin
            n_err++;
            $display("FAIL R4 R9 reservation map: actual %h expected %h", blk_mask_o, em);
        end
        check(int'(blk_count_o), model_blocked_count(), "R4 reserved count");
    endtask

    // Advance the model by one clock edge with the given inputs.
    task automatic model_step(input bit trg, input int lat, input bit res);
        bit have, valid, pop, accept;
        int cells [3];
        int start, idx;
        have   = m_q.size() > 0;
        valid  = have && (m_ph == 1);
        pop    = valid && (m_ch == 31);
        accept = trg && (m_q.size() <= NQ - 3);
        for (int k = 0; k < 3; k++) cells[k] = m_hist[(m_hn - lat + k) & 255];
        if (trg && !accept) m_ovf = 1;
        if (pop) begin
            m_ref[m_q[0]]--;
            void'(m_q.pop_front());
        end
        if (accept) begin
            for (int k = 0; k < 3; k++) begin
                m_q.push_back(cells[k]);
                m_ref[cells[k]]++;
            end
        end
        if (have) begin
            if (valid) begin
                m_ph = 0;
                if (m_ch == 31) begin
                    m_ch = 0;
                    m_sm = (m_sm + 1) % 3;
                end else m_ch++;
            end else m_ph = 1;
        end
        m_hist[m_hn & 255] = m_wr;
        m_hn++;
        start = res ? 0 : (m_wr + 1) % NC;
        for (int i = 0; i < NC; i++) begin
            idx = (start + i) % NC;
            if (m_ref[idx] == 0) begin
                m_wr = idx;
                break;
            end
        end
    endtask

    task automatic tick(input bit trg, input int lat, input bit res);
        trig_i   = trg;
        lat_i    = 7'(lat);
        resync_i = res;
        compare_all();
        model_step(trg, lat, res);
        @(posedge clk);
        @(negedge clk);
        trig_i   = 1'b0;
        resync_i = 1'b0;
    endtask

    task automatic run_to(input int col);
        int guard = 0;
        while (int'(wr_col_o) != col && guard < 400) begin
            tick(0, 3, 0);
            guard++;
        end
        check(int'(wr_col_o), col, "R5 reach column");
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) begin
            @(posedge clk);
            @(negedge clk);
        end
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic check_reset_state();
        check(int'(wr_col_o), 0, "R1 write column");
        check(int'(q_count_o), 0, "R1 queue count");
        check(int'(q_empty_o), 1, "R1 empty flag");
        check(int'(ovf_o), 0, "R1 overflow");
        check(int'(rd_valid_o), 0, "R1 data valid");
        check(int'(blk_count_o), 0, "R1 reserved count");
        check(int'(blk_mask_o == '0), 1, "R1 reservation map");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCH_CYC) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        int guard;
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge clk);
        do_reset();
        check_reset_state();

        // R2: free-running wrap with nothing reserved.
        for (int i = 0; i < 159; i++) tick(0, 3, 0);
        check(int'(wr_col_o), 159, "R2 last column");
        tick(0, 3, 0);
        check(int'(wr_col_o), 0, "R2 wrap to zero");

        // R3: window selection with latency 3 at column 10.
        run_to(10);
        tick(1, 3, 0);
        check(int'(blk_mask_o[9:7]), 7, "R3 columns 7..9 reserved");
        check(int'(q_count_o), 3, "R3 queue count");

        // Reserve 57..59 so the pointer must skip them later.
        run_to(60);
        tick(1, 3, 0);
        check(int'(blk_mask_o[59:57]), 7, "R3 columns 57..59 reserved");
        tick(0, 3, 0);
        run_to(56);
        tick(0, 3, 0);
        check(int'(wr_col_o), 60, "R5 skip over reserved run");
        tick(0, 3, 0);
        check(int'(wr_col_o), 61, "R5 after skip");

        // R6: the window straddles the reserved run.
        tick(1, 3, 0);
        check(int'(blk_mask_o[55]), 1, "R6 first cell before run");
        check(int'(blk_mask_o[56]), 1, "R6 second cell before run");
        check(int'(blk_mask_o[60]), 1, "R6 third cell after run");

        // R7: burst beyond the queue capacity.
        for (int i = 0; i < 10; i++) begin
            tick(1, 20, 0);
            tick(0, 3, 0);
            tick(0, 3, 0);
        end
        check(int'(ovf_o), 1, "R7 overflow after burst");

        // R9: drain, every reservation released.
        guard = 0;
        while (!q_empty_o && guard < 6000) begin
            tick(0, 3, 0);
            guard++;
        end
        tick(0, 3, 0);
        check(int'(blk_count_o), 0, "R9 all released after drain");
        check(int'(ovf_o), 1, "R7 overflow stays set");

        // R10: resync with column 0 reserved lands on the lowest free column.
        run_to(3);
        tick(1, 3, 0);
        tick(0, 3, 1);
        check(int'(wr_col_o), 3, "R10 lowest free column");
        check(int'(q_count_o), 3, "R10 queue kept");
        tick(0, 3, 0);
        check(int'(wr_col_o), 4, "R10 continues upward");

        // Reset again: overflow clears.
        do_reset();
        check_reset_state();
        for (int i = 0; i < 140; i++) tick(0, 3, 0);

        // Random stimulus against the model.
        for (int i = 0; i < 20000; i++) begin
            bit trg, res;
            int lat;
            trg = ($urandom_range(0, 149) == 0) || ((i % 4000) < 40 && (i % 3) == 0);
            res = ($urandom_range(0, 2999) == 0);
            lat = $urandom_range(3, 127);
            tick(trg, lat, res);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule